// File: doc/BRIEF.md
# Carry-save multi-operand adder tree

This block adds a parameterised number of unsigned operands of equal width in one combinational path. The result carries the full precision. Operands arrive packed side by side on a single input bus. The block first reduces them with layers of three-input, two-output carry-save compressors. Every compressor in a layer works in parallel, and the layers repeat until only two vectors remain. A two-operand adder then joins those two vectors. In that adder each carry is a flat OR of generate terms, each gated by the propagate terms above it, so no carry ripples from bit to bit.

The block has no clock and no state, so a state-machine view does not apply. The number of compression layers is fixed at elaboration from the operand count, and it grows roughly as the logarithm to base 3/2 of that count. Inside the block every vector is zero-extended to the result width, so no carry is dropped between layers. A caller can use one operand to pass a value straight through, or two operands to get a plain adder.

Top module: `csa_tree_sum`

## Requirements
- R1: `sum_out` equals the arithmetic sum of all NUM_OPS operands, taken as unsigned numbers, and is OP_W + clog2(NUM_OPS) bits wide.
- R2: Operand k occupies bits [k*OP_W + OP_W-1 : k*OP_W] of `ops_flat`, and every operand has equal weight in the sum.
- R3: When every operand is zero, `sum_out` is zero.
- R4: When every operand is all ones, `sum_out` equals NUM_OPS * (2^OP_W - 1), with no high bit lost.
- R5: Each 3:2 compressor outputs a bitwise XOR vector and a majority vector shifted up one place, and their sum equals the sum of its three inputs.
- R6: In each layer the vectors are taken in groups of three, and any one or two left over pass unchanged to the next layer. Each layer leaves the total sum unchanged.
- R7: In the final adder, the carry out of bit i is the OR over j <= i of (x_j AND y_j AND every (x_k OR y_k) for j < k <= i). This agrees with the bit-serial carry recurrence.
- R8: The output is purely combinational. It reflects a new input value without any clock edge.
- R9: With NUM_OPS = 1 the single operand appears unchanged at the output. With NUM_OPS = 2 no compression layer is built and only the final adder remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_flat | input | NUM_OPS*OP_W | Packed unsigned operands, operand k in slice k |
| sum_out | output | OP_W+clog2(NUM_OPS) | Full-precision sum of all operands |

## Verification
The bench targets the all-ones set. That set drives the largest carries through every layer, and a design that trimmed intermediate widths would return a wrapped, too-small total. It places a single all-ones or one-hot operand in each position in turn. This exposes a slice offset error or a leftover operand lost between layers, either of which gives a sum short by exactly that operand. It also checks the one-operand and two-operand builds. In those builds a wrongly generated layer count would either fail to elaborate or corrupt the pass-through and the plain addition. More than a thousand seeded random sets then catch a bad majority term or a missing propagate term in the flat carry logic, because either fault makes some sums wrong in their upper bits.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

    // Vectors left after one 3:2 layer acting on n vectors
    function automatic int next_count(input int n);
        return (n / 3) * 2 + (n % 3);
    endfunction

    // Number of layers needed to bring m vectors down to at most two
    function automatic int layer_total(input int m);
        int n;
        int r;
        n = m;
        r = 0;
        while (n > 2) begin
            n = next_count(n);
            r = r + 1;
        end
        return r;
    endfunction

    // Vectors present at the input of layer r
    function automatic int count_at(input int m, input int r);
        int n;
        n = m;
        for (int i = 0; i < r; i++) n = next_count(n);
        return n;
    endfunction

    // Starting slot of layer r inside the flat lane bus
    function automatic int slot_at(input int m, input int r);
        int o;
        o = 0;
        for (int i = 0; i < r; i++) o = o + count_at(m, i);
        return o;
    endfunction

endpackage

// File: rtl/csa_compress.sv
module csa_compress #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] u,
    output logic [W-1:0] v
);
    logic [W-2:0] maj;

    assign u   = a ^ b ^ c;
    assign maj = (a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0]);
    assign v   = {maj, 1'b0};

    always_comb begin
        // R5
        sum_keep_chk: assert (({2'b00, a} + {2'b00, b} + {2'b00, c}) == ({2'b00, u} + {2'b00, v}))
            else $error("compressor lost value");
    end
endmodule

// File: rtl/csa_layer.sv
module csa_layer #(
    parameter int W     = 12,
    parameter int N_IN  = 9,
    parameter int N_OUT = 6
) (
    input  logic [N_IN*W-1:0]  src,
    output logic [N_OUT*W-1:0] dst
);
    localparam int GROUPS = N_IN / 3;
    localparam int SPARE  = N_IN % 3;
    localparam int SW     = W + 8;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        csa_compress #(.W(W)) u_cmp (
            .a (src[(3*g+0)*W +: W]),
            .b (src[(3*g+1)*W +: W]),
            .c (src[(3*g+2)*W +: W]),
            .u (dst[(2*g+0)*W +: W]),
            .v (dst[(2*g+1)*W +: W])
        );
    end

    for (genvar k = 0; k < SPARE; k++) begin : g_pass
        assign dst[(2*GROUPS+k)*W +: W] = src[(3*GROUPS+k)*W +: W];
    end

    logic [SW-1:0] tot_in;
    logic [SW-1:0] tot_out;

    always_comb begin
        tot_in  = '0;
        tot_out = '0;
        for (int i = 0; i < N_IN; i++)  tot_in  = tot_in  + {{(SW-W){1'b0}}, src[i*W +: W]};
        for (int i = 0; i < N_OUT; i++) tot_out = tot_out + {{(SW-W){1'b0}}, dst[i*W +: W]};
        // R6
        layer_sum_chk: assert (tot_in == tot_out)
            else $error("layer changed the running total");
    end
endmodule

// File: rtl/cla_flat_add.sv
module cla_flat_add #(
    parameter int W = 12
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    logic [W-2:0] gen;
    logic [W-2:0] prp;
    logic [W-2:0] cy;

    assign gen = x[W-2:0] & y[W-2:0];
    assign prp = x[W-2:0] | y[W-2:0];

    always_comb begin
        logic term;
        for (int i = 0; i < W-1; i++) begin
            cy[i] = 1'b0;
            for (int j = 0; j <= i; j++) begin
                term = gen[j];
                for (int k = j + 1; k <= i; k++) term = term & prp[k];
                cy[i] = cy[i] | term;
            end
        end
    end

    always_comb begin
        s[0] = x[0] ^ y[0];
        for (int i = 1; i < W; i++) s[i] = x[i] ^ y[i] ^ cy[i-1];
    end

    logic [W:0] wide;
    assign wide = {1'b0, x} + {1'b0, y};

    always_comb begin
        // R7
        carry_base_chk: assert (cy[0] == gen[0]) else $error("carry 0 wrong");
        for (int i = 1; i < W-1; i++) begin
            // R7
            ripple_agree_chk: assert (cy[i] == (gen[i] | (prp[i] & cy[i-1])))
                else $error("flat carry disagrees with recurrence");
        end
        // R4
        no_overflow_chk: assert (wide[W] == 1'b0) else $error("final sum overflows");
        // R1
        add_exact_chk: assert (s == wide[W-1:0]) else $error("final adder wrong");
    end
endmodule

// File: rtl/csa_tree_sum.sv
module csa_tree_sum
    import csa_tree_pkg::*;
#(
    parameter int NUM_OPS = 9,
    parameter int OP_W    = 8
) (
    input  logic [NUM_OPS*OP_W-1:0]          ops_flat,
    output logic [OP_W+$clog2(NUM_OPS)-1:0] sum_out
);
    localparam int SUM_W = OP_W + $clog2(NUM_OPS);

    if (NUM_OPS == 1) begin : g_single
        // R9: one operand passes straight through
        assign sum_out = ops_flat;
    end else begin : g_tree
        localparam int LAYERS = layer_total(NUM_OPS);
        localparam int SLOTS  = slot_at(NUM_OPS, LAYERS) + 2;
        localparam int LAST   = slot_at(NUM_OPS, LAYERS);

        logic [SLOTS*SUM_W-1:0] lanes;

        for (genvar k = 0; k < NUM_OPS; k++) begin : g_ext
            assign lanes[k*SUM_W +: SUM_W] = {{(SUM_W-OP_W){1'b0}}, ops_flat[k*OP_W +: OP_W]};
        end

        for (genvar r = 0; r < LAYERS; r++) begin : g_layer
            localparam int NI = count_at(NUM_OPS, r);
            localparam int NO = count_at(NUM_OPS, r + 1);
            localparam int SI = slot_at(NUM_OPS, r);
            localparam int SO = slot_at(NUM_OPS, r + 1);
            csa_layer #(.W(SUM_W), .N_IN(NI), .N_OUT(NO)) u_layer (
                .src (lanes[SI*SUM_W +: NI*SUM_W]),
                .dst (lanes[SO*SUM_W +: NO*SUM_W])
            );
        end

        cla_flat_add #(.W(SUM_W)) u_final (
            .x (lanes[LAST*SUM_W +: SUM_W]),
            .y (lanes[(LAST+1)*SUM_W +: SUM_W]),
            .s (sum_out)
        );
    end
endmodule

// File: tb/sim_csa_tree_sum.sv
module sim_csa_tree_sum;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [71:0] ops0 = '0;
    logic [11:0] res0;
    logic [15:0] ops1 = '0;
    logic [8:0]  res1;
    logic [7:0]  ops2 = '0;
    logic [7:0]  res2;

    csa_tree_sum #(.NUM_OPS(9), .OP_W(8)) u0 (.ops_flat(ops0), .sum_out(res0));
    csa_tree_sum #(.NUM_OPS(2), .OP_W(8)) u1 (.ops_flat(ops1), .sum_out(res1));
    csa_tree_sum #(.NUM_OPS(1), .OP_W(8)) u2 (.ops_flat(ops2), .sum_out(res2));

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    function automatic logic [11:0] ref9(input logic [71:0] v);
        logic [11:0] acc = '0;
        for (int k = 0; k < 9; k++) acc = acc + {4'h0, v[k*8 +: 8]};
        return acc;
    endfunction

    function automatic logic [8:0] ref2(input logic [15:0] v);
        return {1'b0, v[7:0]} + {1'b0, v[15:8]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put9(input logic [71:0] v, input string req);
        @(negedge clk);
        ops0 = v;
        #1;
        check(req, {20'h0, res0}, {20'h0, ref9(v)});
    endtask

    initial begin
        logic [71:0] v;
        logic [31:0] seed;
        seed = $urandom(32'h1234abcd);
        #10;
        // R3: all zero on the main build
        put9('0, "R3");
        // R4: all ones gives 9*255
        @(negedge clk);
        ops0 = '1;
        #1;
        check("R4", {20'h0, res0}, 32'd2295);
        // R2 and R6: one full operand in each slot, others zero
        for (int k = 0; k < 9; k++) begin
            v = '0;
            v[k*8 +: 8] = 8'hff;
            put9(v, "R2");
            @(negedge clk);
            v = '1;
            v[k*8 +: 8] = 8'h00;
            ops0 = v;
            #1;
            check("R6", {20'h0, res0}, 32'd2040);
        end
        // R2: one-hot bit in each operand
        for (int k = 0; k < 9; k++) begin
            v = '0;
            v[k*8 + (k % 8)] = 1'b1;
            put9(v, "R2");
        end
        // R8: change input mid-cycle without a clock edge
        @(posedge clk);
        #1;
        ops0 = {9{8'h01}};
        #1;
        check("R8", {20'h0, res0}, 32'd9);
        ops0 = {9{8'h80}};
        #1;
        check("R8", {20'h0, res0}, 32'd1152);
        // R1, R5, R7: seeded random sets
        for (int n = 0; n < 1200; n++) begin
            v = {$urandom, $urandom, $urandom};
            if (n % 5 == 0) v = v | {9{8'hf0}};
            put9(v, "R1");
        end
        // R9: two-operand and one-operand builds
        @(negedge clk);
        ops1 = '0; ops2 = '0;
        #1;
        check("R9", {23'h0, res1}, 32'd0);
        check("R9", {24'h0, res2}, 32'd0);
        @(negedge clk);
        ops1 = '1; ops2 = '1;
        #1;
        check("R9", {23'h0, res1}, 32'd510);
        check("R9", {24'h0, res2}, 32'd255);
        for (int n = 0; n < 200; n++) begin
            logic [15:0] a;
            logic [7:0]  b;
            a = $urandom;
            b = $urandom;
            @(negedge clk);
            ops1 = a; ops2 = b;
            #1;
            check("R9", {23'h0, res1}, {23'h0, ref2(a)});
            check("R9", {24'h0, res2}, {24'h0, b});
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - bad, total);
            $finish;
        end
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
            $display("%0d/%0d checks passed", total - bad, total);
            $finish;
        end
    end
endmodule